// File: doc/BRIEF.md
# Synchronous Slave-FIFO Stream Writer

This block sits in FPGA fabric on the write side of a synchronous 32-bit slave-FIFO port that feeds a USB peripheral controller. It drives an active-low chip select, an active-low write strobe and the data bus. All three are timed to the interface clock. It generates a test stream in which every word holds two 16-bit lanes. The upper lane carries a framed counter sequence. The lower lane carries an auxiliary channel taken from an input.

Writing is controlled by two flags from the controller, and both pass through a sampling register. The buffer-ready flag lets a burst begin. The active-low watermark flag ends it. Once the sampled watermark flag goes low, a fixed number of further words is written, and then the strobe is released. The controller's buffer therefore fills exactly and is never overrun.

The frame counter advances only on words that are actually written. Pauses, rate throttling and stop/restart cycles therefore never drop or repeat a word. An enable input and a clock-divide ratio set the word rate without touching the flag protocol.

Top module: `sfw_stream_writer`

## Requirements
- R1: While reset is asserted, and after reset until a burst starts, `slv_cs_n` and `slv_wr_n` are both high.
- R2: A burst starts only when the sampled ready flag is high and the sampled watermark flag is high, with `enable` high. With ready low, or with the watermark flag low, no word is written.
- R3: `slv_wr_n` is low only while `slv_cs_n` is low. `slv_cs_n` stays low for the whole of a burst, including the words written after the watermark.
- R4: Each written word carries lane A in bits [31:16] and `aux_data` (as seen at the write edge) in bits [15:0]. Lane A repeats a 16-word frame: 0x00FF, then 5, then 2, 3, ... 15.
- R5: No lane-A value is skipped or repeated across pauses, throttling or stop/restart; the sequence continues at the next word.
- R6: When the ready flag falls during a burst, writing does not stop.
- R7: After the clock edge at which the watermark flag is sampled low, exactly 4 more words are written, at any rate and across enable pauses. After that, `slv_cs_n` returns high.
- R8: After a stop, the writer stays idle until the ready flag is sampled high again.
- R9: While `enable` is low, no word is written.
- R10: With `enable` high during a burst and `div_ratio` = D, words are written exactly once every D+1 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows writes when high |
| div_ratio | input | 8 | Rate divider: one write slot every div_ratio+1 cycles |
| flag_ready | input | 1 | Controller buffer-ready flag, active high |
| flag_wm_n | input | 1 | Controller watermark flag, low when near full |
| aux_data | input | 16 | Auxiliary channel placed in lane B |
| slv_cs_n | output | 1 | Chip select, active low |
| slv_wr_n | output | 1 | Write strobe, active low |
| slv_data | output | 32 | Write data bus |

## Verification
On every cycle, the assertions check four things:
- the strobe stays inside chip select;
- an idle writer never leaves idle without the sampled ready flag;
- a burst with the watermark flag high never ends;
- the number of words written after the watermark goes low never exceeds the post-watermark allowance.

Some behaviour only the bench scenarios can show, by comparing every written word against the queued frame sequence:
- the exact count of post-watermark words;
- continuity of the lane-A sequence across pauses and restarts;
- the write spacing under the divider;
- staying idle until ready returns.

// File: rtl/sfw_pkg.sv
package sfw_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_BURST = 2'd1,
      ST_TAIL  = 2'd2
   } wr_state_e;

endpackage

// File: rtl/sfw_flag_sync.sv
module sfw_flag_sync #(
   parameter int unsigned STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rdy_in,
   input  logic wm_n_in,
   output logic rdy_q,
   output logic wm_q
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("sfw_flag_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0] rdy_pipe;
   logic [STAGES-1:0] wm_pipe;

   // watermark resets low: the buffer is treated as near full until the controller says otherwise
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_pipe <= '0;
         wm_pipe  <= '0;
      end else begin
         for (int s = STAGES - 1; s > 0; s--) begin
            rdy_pipe[s] <= rdy_pipe[s-1];
            wm_pipe[s]  <= wm_pipe[s-1];
         end
         rdy_pipe[0] <= rdy_in;
         wm_pipe[0]  <= wm_n_in;
      end
   end

   assign rdy_q = rdy_pipe[STAGES-1];
   assign wm_q  = wm_pipe[STAGES-1];

endmodule

// File: rtl/sfw_rate_div.sv
module sfw_rate_div #(
   parameter int unsigned DIV_W   = 8,
   parameter bit          USE_DIV = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_ratio,
   output logic             tick
);

   generate
      if (DIV_W < 1) begin : g_bad_width
         $error("sfw_rate_div: DIV_W must be at least 1");
      end

      if (USE_DIV) begin : g_div
         logic [DIV_W-1:0] cnt;

         // free-running slot counter; >= keeps the period bounded if the ratio shrinks mid-count
         assign tick = (cnt >= div_ratio);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt <= '0;
            else if (tick) cnt <= '0;
            else cnt <= cnt + 1'b1;
         end
      end else begin : g_nodiv
         logic unused_div;
         assign unused_div = ^{div_ratio, clk, rst_n};
         assign tick = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/sfw_frame_gen.sv
module sfw_frame_gen #(
   parameter int unsigned              LANE_W    = 16,
   parameter int unsigned              FRAME_LEN = 16,
   parameter logic [LANE_W-1:0]        MARKER    = 'h00FF,
   parameter logic [LANE_W-1:0]        HEAD_VAL  = 'd5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   output logic [LANE_W-1:0] lane_a
);

   localparam int unsigned IDX_W = $clog2(FRAME_LEN);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

   generate
      if (FRAME_LEN < 3) begin : g_bad_len
         $error("sfw_frame_gen: FRAME_LEN must be at least 3");
      end
      if (IDX_W > LANE_W) begin : g_bad_lane
         $error("sfw_frame_gen: frame index does not fit in a lane");
      end
   endgenerate

   logic [IDX_W-1:0] idx;

   // the index moves only on written words, so a stalled burst resumes on the next value
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) idx <= '0;
      else if (advance) idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
   end

   always_comb begin
      if (idx == '0) lane_a = MARKER;
      else if (idx == IDX_W'(1)) lane_a = HEAD_VAL;
      else lane_a = LANE_W'(idx);
   end

endmodule

// File: rtl/sfw_write_ctrl.sv
module sfw_write_ctrl
   import sfw_pkg::*;
#(
   parameter int unsigned TAIL_WORDS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic tick,
   input  logic rdy_q,
   input  logic wm_q,
   output logic write_en,
   output logic cs_active
);

   localparam int unsigned CNT_W = $clog2(TAIL_WORDS + 1);
   localparam logic [CNT_W-1:0] TAIL_LOAD = CNT_W'(TAIL_WORDS);

   generate
      if (TAIL_WORDS < 1) begin : g_bad_tail
         $error("sfw_write_ctrl: TAIL_WORDS must be at least 1");
      end
   endgenerate

   wr_state_e        state, state_nx;
   logic [CNT_W-1:0] tail_left, tail_nx;
   logic             stopping, go;
   logic [CNT_W-1:0] left, left_after;

   // the cycle that first sees the low watermark already spends from the allowance
   assign go         = enable & tick;
   assign stopping   = ((state == ST_BURST) && !wm_q) || (state == ST_TAIL);
   assign left       = (state == ST_TAIL) ? tail_left : TAIL_LOAD;
   assign write_en   = go && (((state == ST_BURST) && wm_q) || (stopping && (left != '0)));
   assign left_after = left - CNT_W'(write_en);
   assign cs_active  = (state != ST_IDLE);

   always_comb begin
      state_nx = state;
      tail_nx  = tail_left;
      unique case (state)
         ST_IDLE: begin
            if (enable && rdy_q && wm_q) state_nx = ST_BURST;
         end
         ST_BURST, ST_TAIL: begin
            if (stopping) begin
               tail_nx  = left_after;
               state_nx = (left_after == '0) ? ST_IDLE : ST_TAIL;
            end
         end
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         tail_left <= '0;
      end else begin
         state     <= state_nx;
         tail_left <= tail_nx;
      end
   end

   // R2: leaving idle needs the sampled ready flag
   a_r2_start_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && !rdy_q) |=> (state == ST_IDLE));

   // R6: with the watermark high a running burst cannot end
   a_r6_ready_no_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_BURST && wm_q) |=> (state != ST_IDLE));

endmodule

// File: rtl/sfw_stream_writer.sv
module sfw_stream_writer #(
   parameter int unsigned           DATA_W      = 32,
   parameter int unsigned           FRAME_LEN   = 16,
   parameter logic [DATA_W/2-1:0]   MARKER      = 'h00FF,
   parameter logic [DATA_W/2-1:0]   HEAD_VAL    = 'd5,
   parameter int unsigned           TAIL_WORDS  = 4,
   parameter int unsigned           DIV_W       = 8,
   parameter bit                    USE_DIV     = 1'b1,
   parameter int unsigned           SYNC_STAGES = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 enable,
   input  logic [DIV_W-1:0]     div_ratio,
   input  logic                 flag_ready,
   input  logic                 flag_wm_n,
   input  logic [DATA_W/2-1:0]  aux_data,
   output logic                 slv_cs_n,
   output logic                 slv_wr_n,
   output logic [DATA_W-1:0]    slv_data
);

   localparam int unsigned LANE_W = DATA_W / 2;
   localparam int unsigned CHK_W  = $clog2(TAIL_WORDS + 2) + 1;

   generate
      if ((DATA_W % 2) != 0) begin : g_bad_data_w
         $error("sfw_stream_writer: DATA_W must be even");
      end
   endgenerate

   logic              rdy_q, wm_q, tick, write_en, cs_active;
   logic [LANE_W-1:0] lane_a;

   sfw_flag_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .rdy_in  (flag_ready),
      .wm_n_in (flag_wm_n),
      .rdy_q   (rdy_q),
      .wm_q    (wm_q)
   );

   sfw_rate_div #(.DIV_W(DIV_W), .USE_DIV(USE_DIV)) i_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .div_ratio (div_ratio),
      .tick      (tick)
   );

   sfw_write_ctrl #(.TAIL_WORDS(TAIL_WORDS)) i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .tick      (tick),
      .rdy_q     (rdy_q),
      .wm_q      (wm_q),
      .write_en  (write_en),
      .cs_active (cs_active)
   );

   sfw_frame_gen #(
      .LANE_W    (LANE_W),
      .FRAME_LEN (FRAME_LEN),
      .MARKER    (MARKER),
      .HEAD_VAL  (HEAD_VAL)
   ) i_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (write_en),
      .lane_a  (lane_a)
   );

   assign slv_cs_n = ~cs_active;
   assign slv_wr_n = ~write_en;
   assign slv_data = {lane_a, aux_data};

   // checker: words written while the sampled watermark is low, cleared when the burst ends
   logic [CHK_W-1:0] post_wm_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) post_wm_cnt <= '0;
      else if (slv_cs_n) post_wm_cnt <= '0;
      else if (!wm_q && !slv_wr_n && (post_wm_cnt != '1)) post_wm_cnt <= post_wm_cnt + 1'b1;
   end

   // R7: never more writes after the watermark than the allowance
   a_r7_tail_bound: assert property (@(posedge clk) disable iff (!rst_n)
      post_wm_cnt <= CHK_W'(TAIL_WORDS));

   // R3: the strobe only inside chip select
   a_r3_wr_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
      !slv_wr_n |-> !slv_cs_n);

   // R1: reset holds both control lines inactive
   a_r1_reset_idle: assert property (@(posedge clk)
      !rst_n |-> (slv_cs_n && slv_wr_n));

endmodule

// File: tb/test_sfw_stream_writer.sv
`timescale 1ns/1ps
module test_sfw_stream_writer;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        enable;
   logic [7:0]  div_ratio;
   logic        flag_ready;
   logic        flag_wm_n;
   logic [15:0] aux_data;
   logic        slv_cs_n, slv_wr_n;
   logic [31:0] slv_data;

   always #2.5 clk = ~clk;

   sfw_stream_writer i_sfw_stream_writer (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .div_ratio  (div_ratio),
      .flag_ready (flag_ready),
      .flag_wm_n  (flag_wm_n),
      .aux_data   (aux_data),
      .slv_cs_n   (slv_cs_n),
      .slv_wr_n   (slv_wr_n),
      .slv_data   (slv_data)
   );

   int          checks = 0;
   int          errors = 0;
   bit          done   = 1'b0;
   logic [15:0] exp_q[$];
   int          pushed = 0;
   int          wr_total = 0;
   int          tail_cnt = 0;
   int          cyc = 0;
   int          last_cyc = 0;
   bit          have_last = 1'b0;
   bit          gap_on = 1'b0;
   int          gap_exp = 1;
   logic        wm_edge = 1'b1;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] lane_model(input int n);
      int k = n % 16;
      if (k == 0) return 16'h00FF;
      if (k == 1) return 16'd5;
      return 16'(k);
   endfunction

   // driver side of the scoreboard: queue the lane-A words the stream must carry
   task automatic push_frames(input int words);
      for (int i = 0; i < words; i++) begin
         exp_q.push_back(lane_model(pushed));
         pushed++;
      end
   endtask

   task automatic wait_cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   // bench copy of the flag as seen at each clock edge
   always @(posedge clk) wm_edge <= flag_wm_n;

   initial begin
      aux_data = 16'h0;
      forever begin
         @(negedge clk);
         aux_data = aux_data + 16'h1357;
      end
   end

   // monitor: samples just before each rising edge
   initial begin
      forever begin
         @(negedge clk);
         #2;
         cyc++;
         if (rst_n && !slv_wr_n) begin
            logic [15:0] e;
            check(!slv_cs_n, "R3 strobe inside select", slv_cs_n, 0);
            if (exp_q.size() == 0) begin
               check(1'b0, "R5 unexpected extra word", slv_data, 0);
            end else begin
               e = exp_q.pop_front();
               check(slv_data == {e, aux_data}, "R4 R5 word content", slv_data, {e, aux_data});
            end
            if (!wm_edge) tail_cnt++;
            if (gap_on && have_last)
               check((cyc - last_cyc) == gap_exp, "R10 write spacing", cyc - last_cyc, gap_exp);
            last_cyc  = cyc;
            have_last = 1'b1;
            wr_total++;
         end
      end
   end

   initial begin
      #(5ns * 200000);
      if (!done) begin
         check(1'b0, "watchdog expired", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int base;
      rst_n = 1'b0; enable = 1'b0; div_ratio = 8'd0;
      flag_ready = 1'b0; flag_wm_n = 1'b1;
      push_frames(1000);

      wait_cycles(4);
      #1;
      check(slv_cs_n == 1'b1 && slv_wr_n == 1'b1, "R1 reset state", {slv_cs_n, slv_wr_n}, 2'b11);
      @(negedge clk);
      rst_n = 1'b1;

      // R2: no ready -> nothing written
      enable = 1'b1;
      wait_cycles(10);
      check(wr_total == 0 && slv_cs_n, "R2 idle without ready", wr_total, 0);
      // R2: ready but watermark low -> still nothing
      flag_ready = 1'b1; flag_wm_n = 1'b0;
      wait_cycles(8);
      check(wr_total == 0 && slv_cs_n, "R2 idle with watermark low", wr_total, 0);

      // start a full-rate burst
      flag_wm_n = 1'b1;
      wait_cycles(4);
      gap_on = 1'b1; gap_exp = 1;
      wait_cycles(40);
      gap_on = 1'b0;
      check(slv_cs_n == 1'b0, "R3 select held during burst", slv_cs_n, 0);
      check(wr_total >= 38, "R10 full rate writes", wr_total, 38);

      // R6: ready falls, burst continues
      flag_ready = 1'b0;
      base = wr_total;
      wait_cycles(10);
      check(wr_total - base == 10, "R6 ready drop does not stop", wr_total - base, 10);

      // R7: watermark low -> exactly 4 more words
      tail_cnt = 0;
      flag_wm_n = 1'b0;
      wait_cycles(10);
      check(tail_cnt == 4, "R7 words after watermark", tail_cnt, 4);
      check(slv_cs_n == 1'b1, "R7 select released", slv_cs_n, 1);

      // R8: stays idle until ready returns
      flag_wm_n = 1'b1;
      base = wr_total;
      wait_cycles(10);
      check(wr_total == base && slv_cs_n, "R8 idle while ready low", wr_total - base, 0);
      flag_ready = 1'b1;
      wait_cycles(10);
      check(wr_total > base, "R8 restart on ready", wr_total - base, 1);

      // R9: enable low stops writes
      enable = 1'b0;
      base = wr_total;
      wait_cycles(8);
      check(wr_total == base, "R9 enable low", wr_total - base, 0);
      enable = 1'b1;

      // R10: divide by 3
      div_ratio = 8'd2;
      wait_cycles(5);
      have_last = 1'b0;
      gap_on = 1'b1; gap_exp = 3;
      base = wr_total;
      wait_cycles(30);
      gap_on = 1'b0;
      check(wr_total - base == 10, "R10 throttled count", wr_total - base, 10);

      // R7 at reduced rate
      tail_cnt = 0;
      flag_wm_n = 1'b0;
      wait_cycles(30);
      check(tail_cnt == 4, "R7 tail at divided rate", tail_cnt, 4);
      check(slv_cs_n == 1'b1, "R7 select released divided", slv_cs_n, 1);

      // R7 with an enable pause inside the tail
      div_ratio = 8'd0;
      flag_wm_n = 1'b1;
      wait_cycles(8);
      check(slv_cs_n == 1'b0, "R8 burst resumed", slv_cs_n, 0);
      tail_cnt = 0;
      flag_wm_n = 1'b0;
      wait_cycles(2);
      enable = 1'b0;
      wait_cycles(6);
      check(tail_cnt == 1 && slv_cs_n == 1'b0, "R7 tail paused by enable", tail_cnt, 1);
      enable = 1'b1;
      wait_cycles(10);
      check(tail_cnt == 4, "R7 tail across pause", tail_cnt, 4);
      check(slv_cs_n == 1'b1, "R7 select released after pause", slv_cs_n, 1);

      check(exp_q.size() == 1000 - wr_total, "R5 word count consistent", exp_q.size(), 1000 - wr_total);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule